// File: doc/BRIEF.md
# Low-Power ADC Scan Sequencer

This block is the control engine that sits between a two-channel analog-to-digital converter and a bank of range filters, and runs from a slow always-on clock. Once enabled it powers the converter up, lets it settle for a programmed number of cycles and then scans the two channels, channel 0 first, one handshake per conversion. After every completed pair it signals the filter bank and reads back a vector of filter-match flags. From that vector it decides when a match has been stable long enough to report.

Three operating styles are supported. In single-shot operation exactly one pair is converted, the filter flags are disregarded and a completion pulse is raised before the converter is powered down. In continuous operation the converter stays powered and pairs are taken back to back. In duty-cycled operation the converter is switched off between pairs and woken by an interval timer. Only after a programmed run of identical matching pairs does the block keep the converter on and start the continuous count. A match is reported only when that second count is also met, and any disturbance sends it back to the duty-cycled phase.

Top module: `adc_scan_seq`

## Requirements
- R1: While `enable` is low the block is idle from the next cycle on: `adc_pd` = 1, `chsel` = 0, no strobes. A rising `enable` drops `adc_pd` on the next cycle.
- R2: After `adc_pd` falls, `chsel` stays 0 for `pwrup_time` + 1 cycles (a value of 0 behaves as 1) before channel 0 is selected.
- R3: `chsel` is one-hot-or-zero, with bit 0 selecting channel 0 and bit 1 selecting channel 1. Channel 0 is held until `adc_valid`, then `chsel` is 0 for exactly one cycle, then channel 1 is held until `adc_valid`. `pair_done` is high for one cycle right after the channel-1 handshake, with `chsel` = 0.
- R4: With `oneshot` = 1, one pair is taken. `oneshot_done` pulses for one cycle in the cycle after `pair_done`, and `adc_pd` is then held at 1 with no further pairs and no `match_pulse`, whatever `match_vec` holds, until `enable` is cleared.
- R5: With `lp_mode` = 0, the converter stays powered and channel 0 is selected again in the cycle after each `pair_done`.
- R6: A pair counts when `match_vec` is non-zero. The count grows only while consecutive pairs carry the same vector. `match_pulse` is high for one cycle, in the cycle after the `pair_done` on which the count first reaches `np_target`, and it is not repeated while the vector stays unchanged.
- R7: A pair whose vector differs from the previous pair restarts the count at 1. An all-zero vector restarts the count at 0.
- R8: With `lp_mode` = 1, after a pair that does not complete the duty-cycled count, `adc_pd` is 1 for `wake_time` cycles (0 behaves as 1) and then the power-up sequence of R2 repeats.
- R9: With `lp_mode` = 1, when `lp_target` identical non-zero pairs have been seen, the converter stays on (channel 0 is selected in the next cycle), and `match_pulse` follows after a further `np_target` identical pairs.
- R10: With `lp_mode` = 1, during the continuous phase a pair that breaks the run (changed or zero vector) powers the converter down in the next cycle and returns to the duty-cycled phase.
- R11: While `soft_rst` is high the block is held idle as in R1 and all counts and the stored vector are cleared, so after release a full `np_target` run is needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the sequencer; low forces idle |
| oneshot | input | 1 | Single-pair operation |
| lp_mode | input | 1 | Duty-cycled low-power operation |
| soft_rst | input | 1 | Synchronous clear of state and counts |
| pwrup_time | input | PWR_W | Settling cycles after power-up |
| wake_time | input | WAKE_W | Sleep cycles between duty-cycled pairs |
| lp_target | input | LP_W | Identical pairs needed in the duty-cycled phase |
| np_target | input | NP_W | Identical pairs needed in the continuous phase |
| adc_valid | input | 1 | Conversion-complete handshake |
| match_vec | input | NUM_FILT | Filter-match flags, read in the `pair_done` cycle |
| adc_pd | output | 1 | Converter power-down request |
| chsel | output | 2 | One-hot channel select |
| pair_done | output | 1 | Both channels converted |
| oneshot_done | output | 1 | Single-shot completion pulse |
| match_pulse | output | 1 | Debounced match report |

## Verification
A wrong state or a stale counter shows up at the ports within one scan. A corrupted power-up timer changes the number of cycles between the fall of `adc_pd` and the first channel select. A wrong sleep timer changes the width of the `adc_pd` high window. A debounce counter that is not cleared, or not restarted, moves `match_pulse` to a different pair index, which the bench counts exactly. A phase bit stuck in the wrong value shows up either as the converter staying on after the first duty-cycled pair, or as a missing power-down after a broken run.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [3:0] {
      S_OFF, S_PWRUP, S_SETTLE, S_CH0, S_GAP, S_CH1,
      S_EVAL, S_SLEEP, S_DONE, S_HALT
   } seq_state_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         expire
);
   logic [W-1:0] cnt_q;

   // The count restarts whenever the owning state is left or the limit is met.
   assign expire = run && ((cnt_q + W'(1)) >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run || expire)  cnt_q <= '0;
      else                      cnt_q <= cnt_q + W'(1);
   end
endmodule

// File: rtl/adc_seq_debounce.sv
module adc_seq_debounce #(
   parameter int NUM_FILT = 8,
   parameter int LP_W     = 8,
   parameter int NP_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                lp_mode,
   input  logic                eval,
   input  logic [NUM_FILT-1:0] match_vec,
   input  logic [LP_W-1:0]     lp_target,
   input  logic [NP_W-1:0]     np_target,
   output logic                sleep_after,
   output logic                hit
);
   logic [NUM_FILT-1:0] prev_q;
   logic [LP_W-1:0]     lp_q, lp_next;
   logic [NP_W-1:0]     np_q, np_next;
   logic                lp_phase_q;
   logic                any_m, same_m, keep, lp_done, np_break;

   assign any_m  = |match_vec;
   assign same_m = (match_vec == prev_q);
   assign keep   = any_m && same_m;

   // Counters saturate at their target so a steady vector reports once.
   assign lp_next = keep ? ((lp_q >= lp_target) ? lp_q : lp_q + LP_W'(1))
                         : {{(LP_W-1){1'b0}}, any_m};
   assign np_next = keep ? ((np_q >= np_target) ? np_q : np_q + NP_W'(1))
                         : {{(NP_W-1){1'b0}}, any_m};

   assign lp_done  = any_m && (lp_next >= lp_target);
   assign np_break = lp_mode && !keep;

   assign sleep_after = lp_phase_q ? !lp_done : np_break;
   assign hit = !lp_phase_q && !np_break && any_m && (np_next == np_target)
              && !(keep && (np_q == np_target));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         lp_q       <= '0;
         np_q       <= '0;
         lp_phase_q <= 1'b0;
      end else if (clr) begin
         prev_q     <= '0;
         lp_q       <= '0;
         np_q       <= '0;
         lp_phase_q <= lp_mode;
      end else if (eval) begin
         prev_q <= match_vec;
         if (lp_phase_q) begin
            lp_q <= lp_next;
            np_q <= '0;
            if (lp_done) lp_phase_q <= 1'b0;
         end else if (np_break) begin
            lp_q       <= '0;
            np_q       <= '0;
            lp_phase_q <= 1'b1;
         end else begin
            np_q <= np_next;
         end
      end
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_FILT = 8,
   parameter int PWR_W    = 4,
   parameter int WAKE_W   = 24,
   parameter int LP_W     = 8,
   parameter int NP_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                oneshot,
   input  logic                lp_mode,
   input  logic                soft_rst,
   input  logic [PWR_W-1:0]    pwrup_time,
   input  logic [WAKE_W-1:0]   wake_time,
   input  logic [LP_W-1:0]     lp_target,
   input  logic [NP_W-1:0]     np_target,
   input  logic                adc_valid,
   input  logic [NUM_FILT-1:0] match_vec,
   output logic                adc_pd,
   output logic [1:0]          chsel,
   output logic                pair_done,
   output logic                oneshot_done,
   output logic                match_pulse
);
   localparam int TIMER_W = (WAKE_W > PWR_W) ? WAKE_W : PWR_W;

   generate
      if (NUM_FILT < 1) begin : g_bad_filt
         $error("NUM_FILT must be at least 1");
      end
      if (PWR_W < 1 || WAKE_W < 1 || LP_W < 1 || NP_W < 1) begin : g_bad_width
         $error("all field widths must be at least 1");
      end
   endgenerate

   seq_state_e state_q, state_d;
   logic [TIMER_W-1:0] timer_limit;
   logic timer_run, timer_expire;
   logic go_off, eval, sleep_after, hit, hit_q;

   assign go_off      = !enable || soft_rst;
   assign timer_run   = (state_q == S_PWRUP) || (state_q == S_SLEEP);
   assign timer_limit = (state_q == S_SLEEP) ? TIMER_W'(wake_time)
                                             : TIMER_W'(pwrup_time);
   assign eval        = (state_q == S_EVAL) && !oneshot;

   adc_seq_timer #(.W(TIMER_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (timer_run),
      .limit  (timer_limit),
      .expire (timer_expire)
   );

   adc_seq_debounce #(.NUM_FILT(NUM_FILT), .LP_W(LP_W), .NP_W(NP_W)) u_deb (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (state_q == S_OFF),
      .lp_mode     (lp_mode),
      .eval        (eval),
      .match_vec   (match_vec),
      .lp_target   (lp_target),
      .np_target   (np_target),
      .sleep_after (sleep_after),
      .hit         (hit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_OFF:    if (enable) state_d = S_PWRUP;
         S_PWRUP:  if (timer_expire) state_d = S_SETTLE;
         S_SETTLE: state_d = S_CH0;
         S_CH0:    if (adc_valid) state_d = S_GAP;
         S_GAP:    state_d = S_CH1;
         S_CH1:    if (adc_valid) state_d = S_EVAL;
         S_EVAL: begin
            if (oneshot)          state_d = S_DONE;
            else if (sleep_after) state_d = S_SLEEP;
            else                  state_d = S_CH0;
         end
         S_SLEEP:  if (timer_expire) state_d = S_PWRUP;
         S_DONE:   state_d = S_HALT;
         S_HALT:   state_d = S_HALT;
         default:  state_d = S_OFF;
      endcase
      if (go_off) state_d = S_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_OFF;
         hit_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         hit_q   <= eval && hit && !go_off;
      end
   end

   assign adc_pd       = (state_q == S_OFF) || (state_q == S_SLEEP) ||
                         (state_q == S_DONE) || (state_q == S_HALT);
   assign chsel        = {state_q == S_CH1, state_q == S_CH0};
   assign pair_done    = (state_q == S_EVAL);
   assign oneshot_done = (state_q == S_DONE);
   assign match_pulse  = hit_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       oneshot,
   input logic       soft_rst,
   input logic       adc_valid,
   input logic       adc_pd,
   input logic [1:0] chsel,
   input logic       pair_done,
   input logic       oneshot_done,
   input logic       match_pulse
);
   AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> adc_pd && (chsel == 2'b00) && !pair_done);            // R1
   AST_SETTLE_BEFORE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_pd) |=> (chsel == 2'b00));                               // R2
   AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chsel));                                                  // R3
   AST_GAP_BEFORE_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chsel[1]) |-> ($past(chsel) == 2'b00));                      // R3
   AST_PAIR_AFTER_CH1: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done |-> $past(chsel[1]) && $past(adc_valid));                // R3
   AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      oneshot_done |=> !oneshot_done && adc_pd);                         // R4
   AST_MATCH_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(pair_done) && !$past(oneshot));              // R6
   AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> adc_pd && !pair_done && !match_pulse);                // R11
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (.*);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 0, oneshot = 0, lp_mode = 0, soft_rst = 0, adc_valid = 0;
   logic [3:0]  pwrup_time = 4'd6;
   logic [23:0] wake_time  = 24'd20;
   logic [7:0]  lp_target  = 8'd2;
   logic [15:0] np_target  = 16'd3;
   logic [NF-1:0] match_vec = '0;
   logic adc_pd, pair_done, oneshot_done, match_pulse;
   logic [1:0] chsel;

   int checks = 0, errors = 0;
   int pairs = 0, pulses = 0, last_pulse_pair = 0;
   int wait_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_scan_seq u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .oneshot(oneshot),
      .lp_mode(lp_mode), .soft_rst(soft_rst), .pwrup_time(pwrup_time),
      .wake_time(wake_time), .lp_target(lp_target), .np_target(np_target),
      .adc_valid(adc_valid), .match_vec(match_vec), .adc_pd(adc_pd),
      .chsel(chsel), .pair_done(pair_done), .oneshot_done(oneshot_done),
      .match_pulse(match_pulse)
   );

   // Converter model: answers each select after a short latency.
   initial forever begin
      @(negedge clk);
      if (adc_valid) adc_valid = 1'b0;
      else if (chsel != 2'b00) begin
         if (wait_cnt >= 2) begin adc_valid = 1'b1; wait_cnt = 0; end
         else wait_cnt++;
      end else wait_cnt = 0;
   end

   // Event monitor.
   initial forever begin
      @(negedge clk);
      if (pair_done) pairs++;
      if (match_pulse) begin pulses++; last_pulse_pair = pairs; end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic wait_pairs(input int n);
      int g = 0;
      while (pairs < n && g < 20000) begin step(); g++; end
      chk("timeout", "pairs reached", pairs, n);
   endtask

   task automatic restart();
      enable = 1'b0;
      step(); step();
      pairs = 0; pulses = 0; last_pulse_pair = 0;
      enable = 1'b1;
   endtask

   task automatic t_reset();
      step();
      chk("R1", "pd in reset", adc_pd, 1);
      chk("R1", "chsel in reset", chsel, 0);
      rst_n = 1'b1;
      step(); step();
      chk("R1", "pd idle", adc_pd, 1);
      chk("R1", "pair idle", pair_done, 0);
   endtask

   task automatic t_powerup_order();
      int n = 0;
      lp_mode = 0; oneshot = 0; pwrup_time = 4'd6; np_target = 16'd100; match_vec = 8'h01;
      restart();
      step();
      chk("R1", "pd after enable", adc_pd, 0);
      while (chsel == 2'b00 && n < 200) begin n++; step(); end
      chk("R2", "settle cycles", n, 7);
      chk("R3", "first select ch0", chsel, 1);
      while (chsel == 2'b01) step();
      chk("R3", "gap select", chsel, 0);
      step();
      chk("R3", "ch1 after gap", chsel, 2);
      while (chsel == 2'b10) step();
      chk("R3", "pair strobe", pair_done, 1);
      chk("R3", "chsel at strobe", chsel, 0);
      step();
      chk("R5", "rescan ch0", chsel, 1);
      chk("R5", "stays powered", adc_pd, 0);
      enable = 1'b0;
      step();
      chk("R1", "pd after disable", adc_pd, 1);
      chk("R1", "chsel after disable", chsel, 0);
   endtask

   task automatic t_oneshot();
      int g = 0;
      logic prev = 0;
      oneshot = 1; np_target = 16'd1; match_vec = 8'hFF; pwrup_time = 4'd2;
      restart();
      while (!oneshot_done && g < 500) begin prev = pair_done; step(); g++; end
      chk("R4", "done follows pair", prev, 1);
      step();
      chk("R4", "done one cycle", oneshot_done, 0);
      chk("R4", "pd after done", adc_pd, 1);
      repeat (40) step();
      chk("R4", "single pair", pairs, 1);
      chk("R4", "no match report", pulses, 0);
      oneshot = 0;
   endtask

   task automatic t_normal();
      int pd_seen = 0;
      lp_mode = 0; np_target = 16'd3; match_vec = 8'h05; pwrup_time = 4'd2;
      restart();
      wait_pairs(1);
      while (pairs < 8) begin step(); if (adc_pd) pd_seen++; end
      chk("R5", "pd during scan", pd_seen, 0);
      step();
      chk("R6", "pulse count", pulses, 1);
      chk("R6", "pulse pair index", last_pulse_pair, 3);
   endtask

   task automatic t_change();
      np_target = 16'd3; match_vec = 8'h05;
      restart();
      wait_pairs(2); step();
      match_vec = 8'h30;
      wait_pairs(7); step();
      chk("R7", "pulses after change", pulses, 1);
      chk("R7", "restart at change", last_pulse_pair, 5);
      match_vec = 8'h00;
      wait_pairs(8); step();
      match_vec = 8'h30;
      wait_pairs(12); step();
      chk("R7", "pulses after zero", pulses, 2);
      chk("R7", "restart after zero", last_pulse_pair, 11);
   endtask

   task automatic t_lowpower();
      int n = 0;
      lp_mode = 1; lp_target = 8'd2; np_target = 16'd2; wake_time = 24'd20;
      pwrup_time = 4'd3; match_vec = 8'h11;
      restart();
      wait_pairs(1);
      step();
      chk("R8", "pd after first pair", adc_pd, 1);
      while (adc_pd && n < 1000) begin n++; step(); end
      chk("R8", "sleep cycles", n, 20);
      wait_pairs(2); step();
      chk("R9", "stays on after lp count", adc_pd, 0);
      chk("R9", "rescan ch0", chsel, 1);
      wait_pairs(4); step();
      chk("R9", "pulse count", pulses, 1);
      chk("R9", "pulse pair index", last_pulse_pair, 4);
      match_vec = 8'h22;
      wait_pairs(5); step();
      chk("R10", "pd after break", adc_pd, 1);
      chk("R10", "no extra pulse", pulses, 1);
      lp_mode = 0;
   endtask

   task automatic t_softrst();
      lp_mode = 0; np_target = 16'd3; match_vec = 8'h03; pwrup_time = 4'd2;
      restart();
      wait_pairs(2); step();
      soft_rst = 1'b1;
      step();
      chk("R11", "pd while held", adc_pd, 1);
      chk("R11", "chsel while held", chsel, 0);
      repeat (4) step();
      chk("R11", "no pair while held", pairs, 2);
      soft_rst = 1'b0;
      wait_pairs(6); step();
      chk("R11", "pulse count", pulses, 1);
      chk("R11", "full run after clear", last_pulse_pair, 5);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_powerup_order();
      t_oneshot();
      t_normal();
      t_change();
      t_lowpower();
      t_softrst();
      summary();
      $finish;
   end
endmodule